// File: doc/BRIEF.md
# Circular Ring DMA Channel

A single byte-wide DMA channel. Each rising edge on an external request strobe, for example a timer update, makes it move exactly one element, either from a peripheral address to a memory address or the other way. The channel runs as a ring: it keeps a live peripheral cursor and a live memory cursor that are separate from the programmed base addresses. When a lap ends it reloads the remaining count and wraps both cursors without software action.

Clearing and setting the enable bit leaves the ring position untouched, so transfers resume at the slot after the last one that finished. Only a write to the count register rewinds the cursors to the bases. The half-lap and lap-complete flags therefore stay tied to ring position, however often the channel is restarted. Flags sit in a four-bit group inside a shared status word and are cleared through a separate write-ones register. The reads and writes go out on a simple request/acknowledge master port.

Top module: `ring_dma_channel`

## Requirements
- R1: After reset, every register reads zero and `irq` and `bus_req` are low. Register word addresses: 0 control, 1 peripheral base, 2 memory base, 3 count (writes the programmed count, reads the remaining count), 4 status, 5 flag clear.
- R2: Control word bits: 0 enable, 1 complete-interrupt enable, 2 half-interrupt enable, 3 circular, 4 direction (1 = peripheral to memory), 5 peripheral increment, 6 memory increment, 9:8 peripheral size, 11:10 memory size (00 = byte), 13:12 priority. Sizes and priority are stored only. While the channel is enabled, each rising edge of `trig` moves exactly one byte from the source cursor to the destination cursor, even if `trig` is held high.
- R3: With direction 0 the memory cursor is the source and the peripheral cursor is the destination. A cursor whose increment bit is clear stays at the same address.
- R4: Clearing and then setting enable keeps both cursors and the remaining count. The next transfer uses the slot after the last completed one.
- R5: A count write while the channel is disabled loads the remaining count and rewinds both cursors to the current bases. Writing a base register does not move a cursor.
- R6: Writes to the count and base registers are ignored while the channel is enabled.
- R7: In circular mode, when the remaining count reaches zero it reloads to the programmed count and both cursors return to the bases. Otherwise the count stays at zero and later strobes move nothing.
- R8: The half flag is set when floor(count/2) elements of the current lap have moved. The complete flag is set when the lap ends. Both are set at the same ring positions across any number of restarts.
- R9: The status word holds the channel's flag group at bits 4*CH_IDX upward: +0 global (OR of the other three), +1 complete, +2 half, +3 error.
- R10: Writing ones to the clear register clears the matching flags, and zeros leave flags unchanged. A one in the global position clears all three flags.
- R11: `irq` is a registered OR of (complete and its enable) and (half and its enable).
- R12: While the channel runs, the count register reads the programmed count minus the elements moved in the current lap, and it never exceeds the programmed count.
- R13: `bus_req` stays high with a stable `bus_addr` and `bus_we` until `bus_ack`. `bus_we` is high only with `bus_req`. A `bus_err` together with `bus_ack` sets the error flag, clears enable and does not count the element.
- R14: Strobes that arrive while the channel is disabled move nothing, and none is remembered for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Registered read data for the address of the previous cycle |
| trig | input | 1 | Transfer request strobe (rising edge) |
| irq | output | 1 | Channel interrupt |
| bus_req | output | 1 | Master port request |
| bus_we | output | 1 | Master port write (0 = read) |
| bus_addr | output | ADDR_W | Master port address |
| bus_wdata | output | 8 | Master port write byte |
| bus_ack | input | 1 | Master port acknowledge |
| bus_err | input | 1 | Master port error, valid with acknowledge |
| bus_rdata | input | 8 | Master port read byte |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=8 and CH_IDX=2. The flag group then lands at status bits 8 to 11, with complete at bit 9 and half at bit 10. Small counts allow many full laps of 8- and 5-element rings inside a short run, so wraps, odd-count half points and half and complete flags seen after many restarts all occur often. The 16-bit address leaves room for a dedicated error address next to the two ring regions in a 256-byte memory model.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  localparam int REG_AW = 3;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 14;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 14'h3F7F;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_PBASE = 3'd1,
    RA_MBASE = 3'd2,
    RA_COUNT = 3'd3,
    RA_STAT  = 3'd4,
    RA_CLEAR = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] prio;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       rsv;
    logic       minc;
    logic       pinc;
    logic       p2m;
    logic       circ;
    logic       hie;
    logic       cie;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RD   = 2'd1,
    ENG_WR   = 2'd2
  } eng_state_e;

  localparam int FLG_GLB = 0;
  localparam int FLG_TC  = 1;
  localparam int FLG_HT  = 2;
  localparam int FLG_ERR = 3;

endpackage

// File: rtl/rdc_trigger.sv
module rdc_trigger (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic enable,
  input  logic take,
  output logic pending
);

  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      trig_q <= trig;
      if (!enable)
        pending <= 1'b0;
      else if (trig && !trig_q)
        pending <= 1'b1;
      else if (take)
        pending <= 1'b0;
    end
  end

endmodule

// File: rtl/rdc_engine.sv
module rdc_engine
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pending,
  input  logic              p2m,
  input  logic              pinc,
  input  logic              minc,
  input  logic              circ,
  input  logic [ADDR_W-1:0] pbase,
  input  logic [ADDR_W-1:0] mbase,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic              cnt_load,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              take,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic [CNT_W-1:0]  remaining,
  output logic              evt_half,
  output logic              evt_done,
  output logic              evt_err
);

  eng_state_e        state;
  logic [ADDR_W-1:0] cur_p, cur_m;
  logic [ADDR_W-1:0] src_a, dst_a;
  logic [ADDR_W-1:0] nxt_p, nxt_m;
  logic [CNT_W-1:0]  rem_dec, half_mark;

  assign src_a     = p2m ? cur_p : cur_m;
  assign dst_a     = p2m ? cur_m : cur_p;
  assign nxt_p     = cur_p + ADDR_W'(pinc);
  assign nxt_m     = cur_m + ADDR_W'(minc);
  assign rem_dec   = remaining - CNT_W'(1);
  assign half_mark = prog_cnt - (prog_cnt >> 1);
  assign take      = (state == ENG_IDLE) && pending && enable && (remaining != '0);
  assign busy      = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cur_p     <= '0;
      cur_m     <= '0;
      remaining <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      evt_half  <= 1'b0;
      evt_done  <= 1'b0;
      evt_err   <= 1'b0;
    end else begin
      evt_half <= 1'b0;
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (take) begin
            state    <= ENG_RD;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= src_a;
          end
        end
        ENG_RD: begin
          if (bus_ack) begin
            if (bus_err) begin
              evt_err <= 1'b1;
              bus_req <= 1'b0;
              state   <= ENG_IDLE;
            end else begin
              bus_wdata <= bus_rdata;
              bus_we    <= 1'b1;
              bus_addr  <= dst_a;
              state     <= ENG_WR;
            end
          end
        end
        ENG_WR: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            state   <= ENG_IDLE;
            if (bus_err) begin
              evt_err <= 1'b1;
            end else begin
              if (rem_dec == half_mark && rem_dec != '0)
                evt_half <= 1'b1;
              if (rem_dec == '0) begin
                evt_done <= 1'b1;
                if (circ) begin
                  remaining <= prog_cnt;
                  cur_p     <= pbase;
                  cur_m     <= mbase;
                end else begin
                  remaining <= '0;
                  cur_p     <= nxt_p;
                  cur_m     <= nxt_m;
                end
              end else begin
                remaining <= rem_dec;
                cur_p     <= nxt_p;
                cur_m     <= nxt_m;
              end
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
      if (cnt_load) begin
        remaining <= prog_cnt;
        cur_p     <= pbase;
        cur_m     <= mbase;
      end
    end
  end

endmodule

// File: rtl/rdc_regs.sv
module rdc_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_DW = 32,
  parameter int CH_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              evt_half,
  input  logic              evt_done,
  input  logic              evt_err,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] pbase,
  output logic [ADDR_W-1:0] mbase,
  output logic [CNT_W-1:0]  prog_cnt,
  output logic              cnt_load,
  output logic              irq
);

  localparam int GRP_LSB = 4 * CH_IDX;

  logic              f_tc, f_ht, f_err;
  logic [3:0]        clr_grp;
  logic [3:0]        grp;
  logic [REG_DW-1:0] stat_v;
  logic [REG_DW-1:0] rd_mux;
  logic              clr_hit;

  assign clr_hit = reg_we && (reg_addr == RA_CLEAR);
  assign clr_grp = clr_hit ? reg_wdata[GRP_LSB +: 4] : 4'b0000;
  assign grp     = {f_err, f_ht, f_tc, f_tc | f_ht | f_err};

  always_comb begin
    stat_v = '0;
    stat_v[GRP_LSB +: 4] = grp;
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL:  rd_mux = REG_DW'(ctrl);
      RA_PBASE: rd_mux = REG_DW'(pbase);
      RA_MBASE: rd_mux = REG_DW'(mbase);
      RA_COUNT: rd_mux = REG_DW'(remaining);
      RA_STAT:  rd_mux = stat_v;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      pbase     <= '0;
      mbase     <= '0;
      prog_cnt  <= '0;
      cnt_load  <= 1'b0;
      f_tc      <= 1'b0;
      f_ht      <= 1'b0;
      f_err     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      cnt_load <= 1'b0;
      if (reg_we) begin
        unique case (reg_addr)
          RA_CTRL:  ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_MASK);
          RA_PBASE: if (!ctrl.en) pbase <= reg_wdata[ADDR_W-1:0];
          RA_MBASE: if (!ctrl.en) mbase <= reg_wdata[ADDR_W-1:0];
          RA_COUNT: if (!ctrl.en) begin
            prog_cnt <= reg_wdata[CNT_W-1:0];
            cnt_load <= 1'b1;
          end
          default: ;
        endcase
      end
      if (evt_err)
        ctrl.en <= 1'b0;
      f_tc  <= evt_done | (f_tc  & ~(clr_grp[FLG_TC]  | clr_grp[FLG_GLB]));
      f_ht  <= evt_half | (f_ht  & ~(clr_grp[FLG_HT]  | clr_grp[FLG_GLB]));
      f_err <= evt_err  | (f_err & ~(clr_grp[FLG_ERR] | clr_grp[FLG_GLB]));
      irq       <= (f_tc & ctrl.cie) | (f_ht & ctrl.hie);
      reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/ring_dma_channel.sv
module ring_dma_channel
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_DW = 32,
  parameter int CH_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              trig,
  output logic              irq,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [7:0]        bus_rdata
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] pbase, mbase;
  logic [CNT_W-1:0]  prog_cnt, remaining;
  logic              cnt_load, pending, take, busy, ch_en;
  logic              evt_half, evt_done, evt_err;

  assign ch_en = ctrl.en;

  rdc_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_DW(REG_DW), .CH_IDX(CH_IDX)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .remaining(remaining),
    .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err),
    .ctrl(ctrl), .pbase(pbase), .mbase(mbase), .prog_cnt(prog_cnt),
    .cnt_load(cnt_load), .irq(irq)
  );

  rdc_trigger u_trig (
    .clk(clk), .rst(rst), .trig(trig), .enable(ch_en), .take(take), .pending(pending)
  );

  rdc_engine #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_eng (
    .clk(clk), .rst(rst),
    .enable(ch_en), .pending(pending),
    .p2m(ctrl.p2m), .pinc(ctrl.pinc), .minc(ctrl.minc), .circ(ctrl.circ),
    .pbase(pbase), .mbase(mbase), .prog_cnt(prog_cnt), .cnt_load(cnt_load),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .take(take), .busy(busy),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .remaining(remaining),
    .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err)
  );

endmodule

// File: rtl/ring_dma_channel_chk.sv
module ring_dma_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              pending,
  input logic              ch_en,
  input logic [CNT_W-1:0]  remaining,
  input logic [CNT_W-1:0]  prog_cnt,
  input logic              cnt_load,
  input logic              reg_we,
  input logic [2:0]        reg_addr
);

  assert_req_held_R13: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  assert_we_needs_req_R13: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_req);

  assert_start_from_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(pending) && $past(ch_en));

  assert_rem_bounded_R12: assert property (@(posedge clk) disable iff (rst)
    !cnt_load |-> remaining <= prog_cnt);

  assert_count_locked_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == 3'd3 && ch_en |=> $stable(prog_cnt));

endmodule

bind ring_dma_channel ring_dma_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
  .pending(pending), .ch_en(ch_en),
  .remaining(remaining), .prog_cnt(prog_cnt), .cnt_load(cnt_load),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/ring_dma_channel_bench.sv
module ring_dma_channel_bench;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int REG_DW = 32;
  localparam int CH_IDX = 2;
  localparam int GL     = 4 * CH_IDX;

  localparam logic [7:0] ERR_ADDR = 8'hEE;
  localparam logic [31:0] C_EN = 32'h1, C_CIE = 32'h2, C_HIE = 32'h4, C_CIRC = 32'h8,
                          C_P2M = 32'h10, C_PINC = 32'h20, C_MINC = 32'h40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [REG_DW-1:0] reg_wdata = '0;
  logic [REG_DW-1:0] reg_rdata;
  logic              trig = 1'b0;
  logic              irq;
  logic              bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic              bus_ack, bus_err;
  logic [7:0]        bus_rdata;

  always #4 clk = ~clk;

  ring_dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_DW(REG_DW), .CH_IDX(CH_IDX))
  u_ring_dma_channel (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig(trig), .irq(irq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // memory model: one-cycle acknowledge, error at ERR_ADDR
  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else begin
      bus_ack <= bus_req && !bus_ack;
      bus_err <= bus_req && !bus_ack && (bus_addr[7:0] == ERR_ADDR);
      if (bus_req && !bus_ack) begin
        bus_rdata <= mem[bus_addr[7:0]];
        if (bus_we && bus_addr[7:0] != ERR_ADDR) mem[bus_addr[7:0]] <= bus_wdata;
      end
    end
  end

  // reference model state
  logic [7:0]  shadow [0:255];
  logic [31:0] m_ctrl;
  int          m_pb, m_mb, m_prog, m_rem, m_cp, m_cm;
  bit          m_tc, m_ht, m_er;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp();
    logic [3:0] g;
    g = {m_er, m_ht, m_tc, m_er | m_ht | m_tc};
    return 32'(g) << GL;
  endfunction

  function automatic bit irq_exp();
    return (m_tc && m_ctrl[1]) || (m_ht && m_ctrl[2]);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_ctrl = d & 32'h3F7F;
      3'd1: if (!m_ctrl[0]) m_pb = int'(d[ADDR_W-1:0]);
      3'd2: if (!m_ctrl[0]) m_mb = int'(d[ADDR_W-1:0]);
      3'd3: if (!m_ctrl[0]) begin
        m_prog = int'(d[CNT_W-1:0]); m_rem = m_prog; m_cp = m_pb; m_cm = m_mb;
      end
      3'd5: begin
        if (d[GL] || d[GL+1]) m_tc = 1'b0;
        if (d[GL] || d[GL+2]) m_ht = 1'b0;
        if (d[GL] || d[GL+3]) m_er = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    rd(3'd3, v); check({tag, " R12 count"}, v, 32'(m_rem));
    rd(3'd4, v); check({tag, " R9 status"}, v, stat_exp());
    check({tag, " R11 irq"}, 32'(irq), 32'(irq_exp()));
  endtask

  // one strobe, model update, checks on destination byte, count, flags, irq
  task automatic strobe(input string tag, input int hold);
    int src, dst;
    bit moved;
    moved = 1'b0;
    src = m_ctrl[4] ? m_cp : m_cm;
    dst = m_ctrl[4] ? m_cm : m_cp;
    @(negedge clk); trig = 1'b1;
    repeat (hold) @(negedge clk);
    trig = 1'b0;
    repeat (10) @(negedge clk);
    if (m_ctrl[0] && m_rem != 0) begin
      if ((src & 255) == int'(ERR_ADDR) || (dst & 255) == int'(ERR_ADDR)) begin
        m_er = 1'b1; m_ctrl[0] = 1'b0;
      end else begin
        moved = 1'b1;
        shadow[dst & 255] = shadow[src & 255];
        m_rem--;
        m_cp += int'(m_ctrl[5]); m_cm += int'(m_ctrl[6]);
        if (m_rem == m_prog - m_prog / 2 && m_rem != 0) m_ht = 1'b1;
        if (m_rem == 0) begin
          m_tc = 1'b1;
          if (m_ctrl[3]) begin m_rem = m_prog; m_cp = m_pb; m_cm = m_mb; end
        end
      end
    end
    if (moved) check({tag, " R2 dest byte"}, 32'(mem[dst & 255]), 32'(shadow[dst & 255]));
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] run;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) shadow[i] = pat(i);
    m_ctrl = 0; m_pb = 0; m_mb = 0; m_prog = 0; m_rem = 0; m_cp = 0; m_cm = 0;
    m_tc = 0; m_ht = 0; m_er = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 pbase", v, 0);
    rd(3'd3, v); check("R1 count", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 bus_req", 32'(bus_req), 0);

    // ring of 8, peripheral to memory, circular
    run = C_EN | C_CIE | C_HIE | C_CIRC | C_P2M | C_PINC | C_MINC;
    wr(3'd1, 32'h0010); wr(3'd2, 32'h0080); wr(3'd3, 8);
    wr(3'd0, run);
    strobe("R2 long hold", 20);
    for (int k = 0; k < 3; k++) strobe("R8 to half", 2);
    // R6 locked writes while enabled
    wr(3'd3, 3); wr(3'd1, 32'h0055);
    rd(3'd3, v); check("R6 count locked", v, 32'(m_rem));
    rd(3'd1, v); check("R6 base locked", v, 32'h0010);
    // R10 zeros no effect, then clear half only
    wr(3'd5, 0); rd(3'd4, v); check("R10 zero clear", v, stat_exp());
    wr(3'd5, 32'h4 << GL); rd(3'd4, v); check("R10 half clear", v, stat_exp());
    // R4 disable/enable resume, R14 strobe while disabled
    wr(3'd0, run & ~C_EN);
    strobe("R14 disabled", 2);
    wr(3'd0, run);
    for (int k = 0; k < 4; k++) strobe("R4 resume", 2);
    // R5 base rewrite keeps cursor
    wr(3'd0, run & ~C_EN); wr(3'd1, 32'h0010); wr(3'd2, 32'h0080); wr(3'd0, run);
    strobe("R5 base same", 2);
    // R5 count reload rewinds, R10 global clear
    wr(3'd0, run & ~C_EN); wr(3'd3, 8); wr(3'd5, 32'h1 << GL); wr(3'd0, run);
    check_state("R10 global clear");
    strobe("R5 rewind", 2);

    // random phase on the 8-ring
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6) strobe("R8 random", 1 + int'($urandom % 3));
      else if (op == 6) begin wr(3'd0, run & ~C_EN); wr(3'd0, run); strobe("R4 random", 2); end
      else if (op == 7) begin
        wr(3'd0, run & ~C_EN); wr(3'd3, 1 + ($urandom % 8)); wr(3'd0, run);
        strobe("R7 random", 2);
      end else if (op == 8) begin
        wr(3'd5, ($urandom % 16) << GL); check_state("R10 random");
      end else begin
        wr(3'd0, run & ~C_EN); wr(3'd1, 32'h0010); wr(3'd2, 32'h0080); wr(3'd0, run);
        strobe("R5 random", 2);
      end
    end

    // R7 non-circular count 3
    wr(3'd0, 0); wr(3'd5, 32'h1 << GL); wr(3'd3, 3);
    wr(3'd0, C_EN | C_CIE | C_P2M | C_PINC | C_MINC);
    for (int k = 0; k < 5; k++) strobe("R7 one-shot", 2);

    // R3 memory to peripheral, fixed peripheral address; R8 odd count 5
    wr(3'd0, 0); wr(3'd5, 32'h1 << GL);
    wr(3'd1, 32'h0040); wr(3'd2, 32'h00A0); wr(3'd3, 5);
    wr(3'd0, C_EN | C_HIE | C_CIRC | C_MINC);
    for (int k = 0; k < 7; k++) strobe("R3 fixed dest", 2);

    // R13 bus error
    wr(3'd0, 0); wr(3'd5, 32'h1 << GL);
    wr(3'd1, 32'(ERR_ADDR)); wr(3'd3, 4);
    wr(3'd0, C_EN | C_CIRC | C_P2M | C_MINC);
    strobe("R13 error", 2);
    rd(3'd0, v); check("R13 enable cleared", v, m_ctrl);

    // whole memory against shadow (R2)
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
      check("R2 memory image", 32'(bad), 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule